// File: doc/BRIEF.md
# Overflow-to-Switch Pulse Stretcher

This block sits between a counter's overflow output and its own switch input. The overflow output is a very short pulse made in the fast clock domain. A counter whose count clock runs far slower than that fast clock would never see such a pulse. The block records the pulse when it ends. It then re-times the record onto the falling edge of the slow count clock. The result is a switch level that lasts exactly one count-clock period, so a rising-edge-triggered switch input catches it on the next rising count edge. With that switch event present, the counter's buffered compare value can swap in at the next terminal count, even at very low count rates.

The first stage has no free-running clock. It is a toggle flop clocked by the falling edge of the overflow pulse. The second stage samples that toggle on the falling edge of the count clock. It emits one switch period for each change of the toggle, so each overflow is retired after it has been reported once. The user's counter must have a period setting of at least 2, which is three count cycles per rollover. The overflow pulse must also fall within half a count period of the rising edge that caused it, including flop delay and setup margin.

Top module: `ovf_switch_stretch`

## Requirements
- R1: While `rst_i` is high at a falling count-clock edge, `switch_o` is low at that edge. An overflow recorded before or during reset produces no switch pulse afterwards.
- R2: An overflow pulse only two fast-clock cycles wide, far shorter than a count period, is still registered. The capture happens on the pulse's falling edge.
- R3: When the overflow pulse falls before the next falling count-clock edge, `switch_o` goes high at that falling edge. It is therefore high when sampled just after the following rising count edge.
- R4: `switch_o` stays high for exactly one count-clock period, from one falling edge to the next. A rising-edge consumer sees it high at exactly one rising count edge.
- R5: Each overflow pulse yields exactly one switch pulse.
- R6: With no overflow pulse, `switch_o` stays low.
- R7: Overflows spaced three or more count cycles apart each yield their own switch pulse. Consecutive switch pulses are separated by at least two low count periods.
- R8: An overflow that falls just before a falling count edge is caught at that edge. An overflow that falls after a falling count edge is caught one count period later, at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ovf_i | input | 1 | Short overflow pulse from the fast domain, active high |
| cnt_clk_i | input | 1 | Slow count clock; the output changes on its falling edge |
| rst_i | input | 1 | Reset, active high; sampled on the falling count edge, and clears the capture flop at once |
| switch_o | output | 1 | Stretched switch level, one count period wide per overflow |

## Verification
A capture toggle left stale or unreset appears at the ports as a switch pulse with no overflow behind it, or as a pulse that survives reset. Such a pulse becomes visible one count period after reset is released. A retime stage that fails to follow the toggle shows up within one count period, as a missing pulse, a pulse held for two periods, or a pulse repeated every period. A capture taken on the wrong edge moves the pulse by one count period, and the late-overflow cases expose it at once.

// File: rtl/ovsw_pkg.sv
package ovsw_pkg;

  // State held in the count-clock domain
  typedef struct packed {
    logic seen_tog;   // last capture toggle value taken in
    logic sw;         // stretched switch level
  } retime_state_t;

endpackage

// File: rtl/ovf_edge_capture.sv
// First stage: toggles once per overflow pulse, on the pulse's trailing edge.
// It has no clock of its own, so reset clears it asynchronously.
module ovf_edge_capture (
  input  logic ovf_i,
  input  logic rst_i,
  output logic tog_o
);

  logic tog_q;

  always_ff @(negedge ovf_i or posedge rst_i) begin
    if (rst_i) tog_q <= 1'b0;
    else       tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

endmodule

// File: rtl/ovsw_retime.sv
// Second stage: takes the capture toggle on the falling count-clock edge and
// emits one count period of switch level for every change it sees.
module ovsw_retime
  import ovsw_pkg::*;
(
  input  logic cnt_clk_i,
  input  logic rst_i,
  input  logic cap_tog_i,
  output logic switch_o
);

  retime_state_t st_q;

  always_ff @(negedge cnt_clk_i) begin
    if (rst_i) begin
      st_q <= '0;
    end else begin
      st_q.seen_tog <= cap_tog_i;
      st_q.sw       <= cap_tog_i ^ st_q.seen_tog;
    end
  end

  assign switch_o = st_q.sw;

  // A fresh capture must show up as switch level one edge later
  AST_EVENT_TAKEN: assert property (@(negedge cnt_clk_i) disable iff (rst_i)
    (cap_tog_i != st_q.seen_tog) |=> switch_o); // R3

  // The switch level never lasts more than one count period
  AST_SINGLE_PERIOD: assert property (@(negedge cnt_clk_i) disable iff (rst_i)
    switch_o |=> !switch_o); // R4

endmodule

// File: rtl/ovf_switch_stretch.sv
module ovf_switch_stretch (
  input  logic ovf_i,
  input  logic cnt_clk_i,
  input  logic rst_i,
  output logic switch_o
);

  logic cap_tog;

  ovf_edge_capture u_capture (
    .ovf_i (ovf_i),
    .rst_i (rst_i),
    .tog_o (cap_tog)
  );

  ovsw_retime u_retime (
    .cnt_clk_i (cnt_clk_i),
    .rst_i     (rst_i),
    .cap_tog_i (cap_tog),
    .switch_o  (switch_o)
  );

  // Reset holds the output low
  AST_RESET_QUIET: assert property (@(negedge cnt_clk_i)
    rst_i |=> !switch_o); // R1

  // With rollovers three count cycles apart, pulses keep two low periods between them
  AST_PULSE_SPACING: assert property (@(negedge cnt_clk_i) disable iff (rst_i)
    switch_o |=> ##1 !switch_o); // R7

endmodule

// File: tb/test_ovf_switch_stretch.sv
`timescale 1ns/1ps
module test_ovf_switch_stretch;

  logic fclk = 1'b0;
  logic cnt_clk = 1'b0;
  logic ovf = 1'b0;
  logic rst = 1'b1;
  logic sw;

  int total = 0;
  int bad = 0;
  logic exp_next = 1'b0;
  bit finished = 1'b0;

  // 200 MHz fast clock
  always #2.5 fclk = ~fclk;

  // count clock: 100 ns period, derived from the fast clock
  int cdiv = 0;
  always @(posedge fclk) begin
    if (cdiv == 9) begin
      cdiv = 0;
      cnt_clk = ~cnt_clk;
    end else begin
      cdiv = cdiv + 1;
    end
  end

  ovf_switch_stretch i_ovf_switch_stretch (
    .ovf_i     (ovf),
    .cnt_clk_i (cnt_clk),
    .rst_i     (rst),
    .switch_o  (sw)
  );

  // one bit per count cycle, LSB first; overflows at least 3 cycles apart
  localparam logic [15:0] PAT [6] = '{
    16'h0000, 16'h0001, 16'h0249, 16'h0111, 16'h1009, 16'h0421
  };

  task automatic chk(input logic act, input logic expv, input string req);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: switch=%0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  // Sample just after the rising count edge, then optionally fire a
  // two-fast-cycle overflow early in the cycle.
  task automatic cycle(input logic fire, input string req);
    @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, exp_next, req);
    exp_next = fire;
    if (fire) begin
      ovf = 1'b1;
      @(negedge fclk);
      @(negedge fclk);
      ovf = 1'b0;
    end
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, 1'b0, "R1 reset state");
    rst = 1'b0;
    exp_next = 1'b0;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int p = 0; p < 6; p++) begin
      for (int b = 0; b < 16; b++) begin
        cycle(PAT[p][b], "R2 R3 R4 R5 R6 R7 table");
      end
    end
    cycle(1'b0, "R6 idle");
    cycle(1'b0, "R6 idle");

    // R8: overflow falls just before the falling count edge
    @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, 1'b0, "R8 before late");
    #32.5 ovf = 1'b1;
    #10   ovf = 1'b0;          // falls 5 ns before the falling edge
    exp_next = 1'b1;
    cycle(1'b0, "R8 late capture");
    cycle(1'b0, "R4 R8 one period only");
    cycle(1'b0, "R6 quiet");

    // R8: overflow falls after the falling count edge -> one period later
    @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, 1'b0, "R8 before very late");
    #52.5 ovf = 1'b1;
    #10   ovf = 1'b0;          // falls 15 ns after the falling edge
    exp_next = 1'b0;
    cycle(1'b0, "R8 not yet");
    exp_next = 1'b0;
    @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, 1'b1, "R8 caught next period");
    cycle(1'b0, "R4 R5 single pulse");
    cycle(1'b0, "R5 no repeat");
    cycle(1'b0, "R6 quiet");

    // R1: reset after a captured overflow discards it
    cycle(1'b1, "R1 pre-reset");
    #5 rst = 1'b1;             // overflow already fell; reset before falling edge
    exp_next = 1'b0;
    @(posedge cnt_clk);
    @(negedge fclk);
    chk(sw, 1'b0, "R1 pulse dropped by reset");
    rst = 1'b0;
    cycle(1'b0, "R1 no stale pulse");
    cycle(1'b0, "R1 no stale pulse");
    cycle(1'b0, "R1 no stale pulse");

    // R5 R7 after reset: normal operation resumes
    cycle(1'b1, "R5 post-reset fire");
    cycle(1'b0, "R5 post-reset pulse");
    cycle(1'b0, "R4 post-reset end");
    cycle(1'b1, "R7 spaced fire");
    cycle(1'b0, "R7 spaced pulse");
    cycle(1'b0, "R7 spaced end");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule